// File: doc/BRIEF.md
# I2C Register Access Slave

This block is a slave on a two-wire serial bus. It lets an external master read and write an internal bank of byte-wide registers. A write frame starts with the 7-bit device address and a direction bit of 0. The next byte loads an 8-bit register pointer. Each byte after that is written to the register the pointer selects, and the pointer then advances by one. A read frame returns register contents starting at the pointer, which also advances after every byte.

A read that follows a plain START always begins at register 0x00. To read from some other location, the master writes the pointer and then issues a repeated START in place of a STOP. Locations above a reserved limit (0xC7 by default) accept writes and acknowledge them, but nothing reaches the bank, and reads from them return 0x00.

The bus lines are oversampled by the system clock. Each line passes through a synchronizer and a majority filter before edge detection. SDA is driven only through an active-high pull-low enable. Toward internal logic the block offers two ports:
- a write stream (`wr_valid`/`wr_ready`). A beat is held until it is accepted. Because the bus is never stretched, the sink must accept each beat before the next data byte completes on the bus.
- a plain read lookup. The block presents `rd_addr`, and `rd_data` must follow it one clock later.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `wr_valid` is 0.
- R2: The slave acknowledges an address byte whose upper seven bits equal `dev_addr`. On a mismatch it does not acknowledge, and it then neither acknowledges nor writes anything until the next START or STOP.
- R3: In a write frame (bit 0 of the address byte = 0), the second byte sets the pointer. Every later byte is acknowledged and written to the pointer address, and the pointer then increments.
- R4: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R5: A data byte aimed at an address above 0xC7 is acknowledged, but it produces no write beat. The pointer still increments.
- R6: A read (address bit 0 = 1) directly after a plain START returns register 0x00 first, then consecutive registers. This also holds for each new read frame that follows a STOP.
- R7: If the pointer is written and a repeated START then opens a read, the first byte returned is the register at the written pointer, and later bytes come from the addresses that follow it.
- R8: A read from an address above 0xC7 returns 0x00. The pointer wraps from 0xFF to 0x00.
- R9: After the master answers a read byte with NACK, the slave does not pull SDA low again until a START.
- R10: The slave begins pulling SDA low only while SCL is low.
- R11: A START or STOP seen in the middle of a byte aborts that byte and releases SDA. A START begins a new address phase.
- R12: A low pulse on SDA that lasts one clock while SCL is high is filtered out. It is not taken as a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Configured 7-bit device address |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_valid | output | 1 | Write beat available |
| wr_ready | input | 1 | Sink accepts the write beat |
| wr_addr | output | 8 | Register address of the write beat |
| wr_data | output | 8 | Data of the write beat |
| rd_addr | output | 8 | Current pointer, presented for lookup |
| rd_data | input | 8 | Register content for `rd_addr`, one clock later |

## Verification
The assertions rely on the following properties of the bus and the sink:
- Each SCL phase lasts far longer than the filter latency of about five clocks.
- The master never creates a START or STOP while the slave is pulling SDA low.
- Write back-pressure ends before the next data byte completes.

The stimulus keeps within these limits. It uses 20-clock SCL phases and changes SDA only while SCL is low, except for the deliberate START, STOP and one-clock glitch cases. It releases SDA during every acknowledge and data slot that the slave owns, and it lifts each `wr_ready` stall inside one byte time.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int PTR_W  = 8;
  localparam int DATA_W = 8;
  localparam int BITS_PER_BYTE = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } eng_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  localparam int CW   = $clog2(FILT_LEN + 1);
  localparam int HALF = FILT_LEN / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic [CW-1:0]          ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < FILT_LEN; i++) ones = ones + CW'(win_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      level  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      level  <= (ones > CW'(HALF));
    end
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [PTR_W-1:0] RESV_LIMIT = 8'hC7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_f,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  localparam logic [3:0] LAST_BIT = 4'(BITS_PER_BYTE);

  eng_state_e        state;
  byte_kind_e        kind;
  logic [3:0]        cnt;
  logic [DATA_W-1:0] sh;
  logic [PTR_W-1:0]  ptr;
  logic              rw, bus_busy, rs_flag, mack;
  logic [DATA_W-1:0] tx_byte;

  assign tx_byte = (ptr > RESV_LIMIT) ? '0 : rd_data;
  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= BK_ADDR;
      cnt      <= '0;
      sh       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      bus_busy <= 1'b0;
      rs_flag  <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (start_det) begin
        state    <= ST_RX;
        kind     <= BK_ADDR;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        rs_flag  <= bus_busy;
        bus_busy <= 1'b1;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        bus_busy <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && cnt < LAST_BIT) begin
              sh  <= {sh[DATA_W-2:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              case (kind)
                BK_ADDR: begin
                  if (sh[7:1] == dev_addr) begin
                    rw     <= sh[0];
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                    if (sh[0] && !rs_flag) ptr <= '0;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                BK_PTR: begin
                  ptr    <= sh;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
                default: begin
                  if (ptr <= RESV_LIMIT) begin
                    wr_valid <= 1'b1;
                    wr_addr  <= ptr;
                    wr_data  <= sh;
                  end
                  ptr    <= ptr + 1'b1;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (kind == BK_ADDR && rw) begin
                sda_oe <= ~tx_byte[DATA_W-1];
                sh     <= {tx_byte[DATA_W-2:0], 1'b0};
                cnt    <= 4'd1;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_RX;
                kind   <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~sh[DATA_W-1];
                sh     <= {sh[DATA_W-2:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda_f;
            if (scl_fall) begin
              if (mack) begin
                sda_oe <= ~tx_byte[DATA_W-1];
                sh     <= {tx_byte[DATA_W-2:0], 1'b0};
                cnt    <= 4'd1;
                state  <= ST_TX;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter logic [PTR_W-1:0] RESV_LIMIT = 8'hC7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2cs_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[g]),
      .level(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2cs_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_f),
    .sda      (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cs_engine #(.RESV_LIMIT(RESV_LIMIT)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (dev_addr),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_f    (sda_f),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter logic [7:0] RESV_LIMIT = 8'hC7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R4

  AST_WR_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr <= RESV_LIMIT)); // R5

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f); // R10

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe); // R11

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R11
endmodule

bind i2c_regbank_slave i2cs_checker #(.RESV_LIMIT(RESV_LIMIT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/i2c_regbank_slave_tb_top.sv
module i2c_regbank_slave_tb_top;
  localparam int Q = 10;
  localparam int H = 20;
  localparam logic [6:0] DEV = 7'h4D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_valid, wr_ready;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic sda_line;

  int checks = 0, errors = 0, viol = 0;
  logic [15:0] exp_q[$];
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regbank_slave dut_i (
    .clk(clk), .rst_n(rst_n), .dev_addr(DEV), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(input logic [7:0] a);
    return 8'(int'(a) * 37 + 27);
  endfunction

  function automatic logic [7:0] rexp(input logic [7:0] a);
    return (a > 8'hC7) ? 8'h00 : pat(a);
  endfunction

  always @(posedge clk) rd_data <= pat(rd_addr);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor for the write stream
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3: actual write %h:%h expected none", wr_addr, wr_data);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          errors++;
          $display("FAIL R3: actual %h expected %h", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  // R10 monitor: slave output only changes while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev = sda_oe;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input int gbit);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; wclk(Q);
      scl_m = 1'b1;
      if (i == gbit && b[i]) begin
        wclk(H/2); sda_m = 1'b0; wclk(1); sda_m = 1'b1; wclk(H/2 - 1);
      end else wclk(H);
      scl_m = 1'b0; wclk(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gbit, output logic ack);
    send_bits(b, 8, gbit);
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(H/2);
    ack = ~sda_line; wclk(H/2);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(Q); scl_m = 1'b1; wclk(H/2);
      b[i] = sda_line; wclk(H/2);
      scl_m = 1'b0; wclk(Q);
    end
    sda_m = nack; wclk(Q);
    scl_m = 1'b1; wclk(H);
    scl_m = 1'b0; wclk(Q);
    sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] p, input string req);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, -1, a); chk(req, 16'(a), 16'd1);
    send_byte(p, -1, a);           chk(req, 16'(a), 16'd1);
  endtask

  task automatic open_read(input bit rep, input string req);
    logic a;
    if (rep) bus_rstart(); else bus_start();
    send_byte({DEV, 1'b1}, -1, a); chk(req, 16'(a), 16'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    wr_ready = 1'b1;
    wclk(5);
    // R1 reset state
    chk("R1", {15'd0, sda_oe}, 16'd0);
    chk("R1", {15'd0, wr_valid}, 16'd0);
    rst_n = 1'b1;
    wclk(10);

    // R2/R3 sequential write
    set_ptr(8'h10, "R2");
    exp_q.push_back(16'h10A1); send_byte(8'hA1, -1, a); chk("R3", 16'(a), 16'd1);
    exp_q.push_back(16'h11B2); send_byte(8'hB2, -1, a); chk("R3", 16'(a), 16'd1);
    exp_q.push_back(16'h12C3); send_byte(8'hC3, -1, a); chk("R3", 16'(a), 16'd1);
    bus_stop();
    chk("R3", 16'(exp_q.size()), 16'd0);

    // R4 back-pressure
    wr_ready = 1'b0;
    set_ptr(8'h30, "R4");
    exp_q.push_back(16'h3044); send_byte(8'h44, -1, a);
    wclk(30);
    chk("R4", {7'd0, wr_valid, wr_addr}, {7'd0, 1'b1, 8'h30});
    wclk(60);
    chk("R4", {7'd0, wr_valid, wr_data}, {7'd0, 1'b1, 8'h44});
    wr_ready = 1'b1;
    wclk(4);
    bus_stop();
    chk("R4", 16'(exp_q.size()), 16'd0);

    // R5 reserved writes
    set_ptr(8'hC7, "R5");
    exp_q.push_back(16'hC711); send_byte(8'h11, -1, a); chk("R5", 16'(a), 16'd1);
    send_byte(8'h22, -1, a); chk("R5", 16'(a), 16'd1);
    send_byte(8'h33, -1, a); chk("R5", 16'(a), 16'd1);
    bus_stop(); wclk(10);
    chk("R5", 16'(exp_q.size()), 16'd0);

    // R6 read after plain START begins at 0x00
    open_read(1'b0, "R6");
    recv_byte(1'b0, d); chk("R6", 16'(d), 16'(rexp(8'h00)));
    recv_byte(1'b0, d); chk("R6", 16'(d), 16'(rexp(8'h01)));
    recv_byte(1'b1, d); chk("R6", 16'(d), 16'(rexp(8'h02)));
    bus_stop();
    open_read(1'b0, "R6");
    recv_byte(1'b1, d); chk("R6", 16'(d), 16'(rexp(8'h00)));
    bus_stop();

    // R7 preset pointer then repeated START
    set_ptr(8'h40, "R7");
    open_read(1'b1, "R7");
    recv_byte(1'b0, d); chk("R7", 16'(d), 16'(rexp(8'h40)));
    recv_byte(1'b1, d); chk("R7", 16'(d), 16'(rexp(8'h41)));
    bus_stop();

    // R8 reserved reads and wrap
    set_ptr(8'hFE, "R8");
    open_read(1'b1, "R8");
    recv_byte(1'b0, d); chk("R8", 16'(d), 16'h00);
    recv_byte(1'b0, d); chk("R8", 16'(d), 16'h00);
    recv_byte(1'b1, d); chk("R8", 16'(d), 16'(rexp(8'h00)));
    bus_stop();

    // R2 mismatch ignored until STOP
    bus_start();
    send_byte({7'h3A, 1'b0}, -1, a); chk("R2", 16'(a), 16'd0);
    send_byte(8'h05, -1, a);         chk("R2", 16'(a), 16'd0);
    send_byte(8'h66, -1, a);         chk("R2", 16'(a), 16'd0);
    bus_stop(); wclk(10);
    chk("R2", 16'(exp_q.size()), 16'd0);

    // R9 NACK releases the bus
    set_ptr(8'h05, "R9");
    open_read(1'b1, "R9");
    recv_byte(1'b1, d); chk("R9", 16'(d), 16'(rexp(8'h05)));
    recv_byte(1'b1, d); chk("R9", 16'(d), 16'hFF);
    bus_stop();

    // R11 START and STOP mid-byte abort
    set_ptr(8'h70, "R11");
    send_bits(8'h0F, 3, -1);
    bus_rstart();
    send_byte({DEV, 1'b0}, -1, a); chk("R11", 16'(a), 16'd1);
    send_byte(8'h20, -1, a);       chk("R11", 16'(a), 16'd1);
    exp_q.push_back(16'h2077); send_byte(8'h77, -1, a); chk("R11", 16'(a), 16'd1);
    send_bits(8'h00, 4, -1);
    bus_stop();
    set_ptr(8'h50, "R11");
    exp_q.push_back(16'h5099); send_byte(8'h99, -1, a); chk("R11", 16'(a), 16'd1);
    bus_stop(); wclk(10);
    chk("R11", 16'(exp_q.size()), 16'd0);

    // R12 one-clock glitch during SCL high is filtered
    set_ptr(8'h60, "R12");
    exp_q.push_back(16'h605F); send_byte(8'h5F, 6, a); chk("R12", 16'(a), 16'd1);
    bus_stop(); wclk(10);
    chk("R12", 16'(exp_q.size()), 16'd0);

    chk("R10", 16'(viol), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule